// File: doc/BRIEF.md
# Power Mode Sequencer

This block keeps track of which power mode a small microcontroller core is in and drives the clock and oscillator enables that follow from it. Software writes one control word through a single-cycle write strobe. The word carries the oscillator enables, the system clock select, the light-sleep request, the timer-only halt request, the deep-stop request and the deep-stop return choice. While the core is halted, three separate events end the low-power state: an interrupt request, a falling edge of the timebase source, or a release handshake from the wake-up logic.

The running mode follows from the oscillator bits. With only the fast oscillator on, the core runs from the fast clock. With both oscillators on, either clock can be selected. With only the slow oscillator on, the core runs from the slow clock. Each halted flavour has its own release rule and its own return mode. A write whose oscillator settings would leave the core without its clock raises a one-cycle reset request. A write that asks for two incompatible halts is dropped, and an error pulse is raised instead.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (fast clock only). The fast oscillator, CPU run and peripheral clock are on, and the slow oscillator is off.
- R2: An accepted write with no request bits sets the run mode from the clock bits. fosc=1,sosc=0,csel=0 gives 0. fosc=1,sosc=1,csel=0 gives 1. fosc=1,sosc=1,csel=1 gives 2. fosc=0,sosc=1,csel=1 gives 3. The mode is visible after the write's clock edge.
- R3: A write with the idle bit enters the light halt that matches the resulting run mode: 0→4, 1→5, 3→6, 2→7. `irq_i` returns the block to that run mode one edge later. Until then the mode holds.
- R4: A write with the halt bit enters 8 when csel=0 and 9 when csel=1. Only the timebase clock stays on, and `irq_i` has no effect. `tbt_fall_i` releases 8 to mode 0 and 9 to mode 3, rewriting the oscillator bits to match.
- R5: On release from mode 8 or 9, `tbt_irq_set_o` pulses for one cycle if `tbt_en_i` was 1 at entry. Otherwise it stays 0.
- R6: A write with both oscillators off, with fosc=0 and csel=0, or with sosc=0 and csel=1, pulses `force_rst_o` for one cycle and returns to mode 0.
- R7: A write with idle and halt both 1 pulses `cfg_err_o` and changes no state.
- R8: A write with the stop bit enters mode 10. Both oscillators, the CPU and the peripheral clocks are off, and `stop_active_o` is 1. `stop_rel_i` returns the block to mode 3 if ret_slow was 1, else to a fast-clock run mode (1 if sosc is still on, else 0).
- R9: Writes are ignored in every mode except the run modes 0 to 3.
- R10: A stop write with ret_slow=1 while sosc=0 pulses `cfg_err_o` and changes no state.
- R11: `cpu_run_o` is 1 only in modes 0 to 3. `periph_clk_en_o` is 1 in modes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Control word write strobe |
| wr_fosc_i | input | 1 | Fast oscillator enable bit |
| wr_sosc_i | input | 1 | Slow oscillator enable bit |
| wr_csel_i | input | 1 | System clock select, 1 = slow |
| wr_idle_i | input | 1 | Light halt request |
| wr_halt_i | input | 1 | Timer-only halt request |
| wr_stop_i | input | 1 | Deep stop request |
| wr_ret_slow_i | input | 1 | Stop return to slow mode |
| tbt_en_i | input | 1 | Timebase timer enabled |
| irq_i | input | 1 | Interrupt request |
| tbt_fall_i | input | 1 | Timebase source falling edge |
| stop_rel_i | input | 1 | Stop release handshake |
| mode_o | output | 4 | Current mode code |
| fast_osc_en_o | output | 1 | Fast oscillator enable |
| slow_osc_en_o | output | 1 | Slow oscillator enable |
| cpu_run_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| tbt_clk_en_o | output | 1 | Timebase clock enable |
| stop_active_o | output | 1 | Handed over to the wake-up logic |
| tbt_irq_set_o | output | 1 | Timebase interrupt latch set pulse |
| force_rst_o | output | 1 | Forced reset request pulse |
| cfg_err_o | output | 1 | Conflicting request pulse |

## Verification
The assertions check on every cycle the rules that hold between outputs or from one cycle to the next. Stop always gates both oscillators, and CPU run implies a peripheral clock. A reset request lands in mode 0, and an error pulse leaves the mode unchanged. The halted modes hold until their own release event, and the timebase set pulse appears only on leaving a timer-only halt. Only the bench scenarios show which flavour each write selects and which mode each release lands in. They also show that the oscillator bits are rewritten on release, that writes and interrupts are ignored while halted, and that the timebase pulse depends on the enable sampled at entry.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_NORMAL1 = 4'd0,
    PM_NORMAL2 = 4'd1,
    PM_SLOW2   = 4'd2,
    PM_SLOW1   = 4'd3,
    PM_IDLE1   = 4'd4,
    PM_IDLE2   = 4'd5,
    PM_SLEEP1  = 4'd6,
    PM_SLEEP2  = 4'd7,
    PM_IDLE0   = 4'd8,
    PM_SLEEP0  = 4'd9,
    PM_STOP    = 4'd10
  } pmode_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RST, ACT_ERR, ACT_CFG, ACT_IDLE, ACT_HALT, ACT_STOP
  } wr_act_e;

  typedef struct packed {
    logic fosc;
    logic sosc;
    logic csel;
  } osc_cfg_t;

  localparam osc_cfg_t CFG_FAST_ONLY = '{fosc: 1'b1, sosc: 1'b0, csel: 1'b0};
  localparam osc_cfg_t CFG_SLOW_ONLY = '{fosc: 1'b0, sosc: 1'b1, csel: 1'b1};

  function automatic logic osc_illegal(osc_cfg_t c);
    return (!c.fosc && !c.sosc) || (!c.fosc && !c.csel) || (!c.sosc && c.csel);
  endfunction

  function automatic pmode_e run_of(osc_cfg_t c);
    if (c.csel) return c.fosc ? PM_SLOW2 : PM_SLOW1;
    return c.sosc ? PM_NORMAL2 : PM_NORMAL1;
  endfunction

  function automatic logic is_run(pmode_e m);
    return m inside {PM_NORMAL1, PM_NORMAL2, PM_SLOW2, PM_SLOW1};
  endfunction

  function automatic pmode_e light_of(pmode_e r);
    case (r)
      PM_NORMAL2: return PM_IDLE2;
      PM_SLOW1:   return PM_SLEEP1;
      PM_SLOW2:   return PM_SLEEP2;
      default:    return PM_IDLE1;
    endcase
  endfunction
endpackage

// File: rtl/pwr_wr_decode.sv
module pwr_wr_decode
  import pwr_mode_pkg::*;
(
  input  logic     wr_i,
  input  logic     run_i,
  input  osc_cfg_t cfg_i,
  input  logic     idle_i,
  input  logic     halt_i,
  input  logic     stop_i,
  input  logic     ret_slow_i,
  output wr_act_e  act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (wr_i && run_i) begin
      if (osc_illegal(cfg_i))                    act_o = ACT_RST;
      else if (idle_i && halt_i)                 act_o = ACT_ERR;
      else if (stop_i && ret_slow_i && !cfg_i.sosc) act_o = ACT_ERR;
      else if (stop_i)                           act_o = ACT_STOP;
      else if (halt_i)                           act_o = ACT_HALT;
      else if (idle_i)                           act_o = ACT_IDLE;
      else                                       act_o = ACT_CFG;
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wr_act_e  act_i,
  input  osc_cfg_t wcfg_i,
  input  logic     ret_slow_i,
  input  logic     tbt_en_i,
  input  logic     irq_i,
  input  logic     tbt_fall_i,
  input  logic     stop_rel_i,
  output pmode_e   mode_o,
  output osc_cfg_t cfg_o,
  output logic     tbt_set_o,
  output logic     rst_req_o,
  output logic     err_o
);
  pmode_e   mode_q;
  osc_cfg_t cfg_q;
  logic     ret_slow_q, tbt_arm_q, tbt_set_q, rst_q, err_q;
  osc_cfg_t stop_ret_cfg;

  assign stop_ret_cfg = '{fosc: 1'b1, sosc: cfg_q.sosc, csel: 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= PM_NORMAL1;
      cfg_q      <= CFG_FAST_ONLY;
      ret_slow_q <= 1'b0;
      tbt_arm_q  <= 1'b0;
      tbt_set_q  <= 1'b0;
      rst_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      tbt_set_q <= 1'b0;
      rst_q     <= 1'b0;
      err_q     <= 1'b0;
      case (mode_q)
        PM_NORMAL1, PM_NORMAL2, PM_SLOW2, PM_SLOW1: begin
          case (act_i)
            ACT_RST: begin
              rst_q  <= 1'b1;
              cfg_q  <= CFG_FAST_ONLY;
              mode_q <= PM_NORMAL1;
            end
            ACT_ERR: err_q <= 1'b1;
            ACT_CFG: begin
              cfg_q  <= wcfg_i;
              mode_q <= run_of(wcfg_i);
            end
            ACT_IDLE: begin
              cfg_q  <= wcfg_i;
              mode_q <= light_of(run_of(wcfg_i));
            end
            ACT_HALT: begin
              cfg_q     <= wcfg_i;
              tbt_arm_q <= tbt_en_i;
              mode_q    <= wcfg_i.csel ? PM_SLEEP0 : PM_IDLE0;
            end
            ACT_STOP: begin
              cfg_q      <= wcfg_i;
              ret_slow_q <= ret_slow_i;
              mode_q     <= PM_STOP;
            end
            default: ;
          endcase
        end
        PM_IDLE1, PM_IDLE2, PM_SLEEP1, PM_SLEEP2:
          if (irq_i) mode_q <= run_of(cfg_q);
        PM_IDLE0:
          if (tbt_fall_i) begin
            mode_q    <= PM_NORMAL1;
            cfg_q     <= CFG_FAST_ONLY;
            tbt_set_q <= tbt_arm_q;
          end
        PM_SLEEP0:
          if (tbt_fall_i) begin
            mode_q    <= PM_SLOW1;
            cfg_q     <= CFG_SLOW_ONLY;
            tbt_set_q <= tbt_arm_q;
          end
        PM_STOP:
          if (stop_rel_i) begin
            if (ret_slow_q) begin
              cfg_q  <= CFG_SLOW_ONLY;
              mode_q <= PM_SLOW1;
            end else begin
              cfg_q  <= stop_ret_cfg;
              mode_q <= run_of(stop_ret_cfg);
            end
          end
        default: begin
          mode_q <= PM_NORMAL1;
          cfg_q  <= CFG_FAST_ONLY;
        end
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign cfg_o     = cfg_q;
  assign tbt_set_o = tbt_set_q;
  assign rst_req_o = rst_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_mode_pkg::*;
(
  input  pmode_e   mode_i,
  input  osc_cfg_t cfg_i,
  output logic     fast_osc_en_o,
  output logic     slow_osc_en_o,
  output logic     cpu_run_o,
  output logic     periph_clk_en_o,
  output logic     tbt_clk_en_o,
  output logic     stop_active_o
);
  logic stop_m, light_m;

  assign stop_m  = (mode_i == PM_STOP);
  assign light_m = mode_i inside {PM_IDLE1, PM_IDLE2, PM_SLEEP1, PM_SLEEP2};

  assign fast_osc_en_o   = cfg_i.fosc & ~stop_m;
  assign slow_osc_en_o   = cfg_i.sosc & ~stop_m;
  assign cpu_run_o       = is_run(mode_i);
  assign periph_clk_en_o = is_run(mode_i) | light_m;
  assign tbt_clk_en_o    = ~stop_m;
  assign stop_active_o   = stop_m;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_fosc_i,
  input  logic              wr_sosc_i,
  input  logic              wr_csel_i,
  input  logic              wr_idle_i,
  input  logic              wr_halt_i,
  input  logic              wr_stop_i,
  input  logic              wr_ret_slow_i,
  input  logic              tbt_en_i,
  input  logic              irq_i,
  input  logic              tbt_fall_i,
  input  logic              stop_rel_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              fast_osc_en_o,
  output logic              slow_osc_en_o,
  output logic              cpu_run_o,
  output logic              periph_clk_en_o,
  output logic              tbt_clk_en_o,
  output logic              stop_active_o,
  output logic              tbt_irq_set_o,
  output logic              force_rst_o,
  output logic              cfg_err_o
);
  osc_cfg_t wcfg, cfg_q;
  wr_act_e  act;
  pmode_e   mode_q;

  assign wcfg = '{fosc: wr_fosc_i, sosc: wr_sosc_i, csel: wr_csel_i};

  pwr_wr_decode u_dec (
    .wr_i       (wr_i),
    .run_i      (is_run(mode_q)),
    .cfg_i      (wcfg),
    .idle_i     (wr_idle_i),
    .halt_i     (wr_halt_i),
    .stop_i     (wr_stop_i),
    .ret_slow_i (wr_ret_slow_i),
    .act_o      (act)
  );

  pwr_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .wcfg_i     (wcfg),
    .ret_slow_i (wr_ret_slow_i),
    .tbt_en_i   (tbt_en_i),
    .irq_i      (irq_i),
    .tbt_fall_i (tbt_fall_i),
    .stop_rel_i (stop_rel_i),
    .mode_o     (mode_q),
    .cfg_o      (cfg_q),
    .tbt_set_o  (tbt_irq_set_o),
    .rst_req_o  (force_rst_o),
    .err_o      (cfg_err_o)
  );

  pwr_out_dec u_out (
    .mode_i          (mode_q),
    .cfg_i           (cfg_q),
    .fast_osc_en_o   (fast_osc_en_o),
    .slow_osc_en_o   (slow_osc_en_o),
    .cpu_run_o       (cpu_run_o),
    .periph_clk_en_o (periph_clk_en_o),
    .tbt_clk_en_o    (tbt_clk_en_o),
    .stop_active_o   (stop_active_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              wr_fosc_i,
  input logic              wr_sosc_i,
  input logic              wr_csel_i,
  input logic              wr_idle_i,
  input logic              wr_halt_i,
  input logic              wr_stop_i,
  input logic              wr_ret_slow_i,
  input logic              tbt_en_i,
  input logic              irq_i,
  input logic              tbt_fall_i,
  input logic              stop_rel_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              fast_osc_en_o,
  input logic              slow_osc_en_o,
  input logic              cpu_run_o,
  input logic              periph_clk_en_o,
  input logic              tbt_clk_en_o,
  input logic              stop_active_o,
  input logic              tbt_irq_set_o,
  input logic              force_rst_o,
  input logic              cfg_err_o
);
  assert_stop_osc_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_active_o |-> (!fast_osc_en_o && !slow_osc_en_o && !cpu_run_o));

  assert_run_has_periph_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> periph_clk_en_o);

  assert_run_has_osc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> (fast_osc_en_o || slow_osc_en_o));

  assert_force_rst_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_rst_o |-> (mode_o == PM_NORMAL1 && fast_osc_en_o && !slow_osc_en_o));

  assert_err_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $stable(mode_o));

  assert_light_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o inside {PM_IDLE1, PM_IDLE2, PM_SLEEP1, PM_SLEEP2} && !irq_i) |=> $stable(mode_o));

  assert_halt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o inside {PM_IDLE0, PM_SLEEP0} && !tbt_fall_i) |=> $stable(mode_o));

  assert_tbt_set_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbt_irq_set_o |-> ($past(mode_o) inside {PM_IDLE0, PM_SLEEP0}));

  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_active_o && !stop_rel_i) |=> stop_active_o);

  assert_halt_gates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o inside {PM_IDLE0, PM_SLEEP0}) |-> (!periph_clk_en_o && tbt_clk_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (.*);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, fosc = 0, sosc = 0, csel = 0, idle = 0, halt = 0, stp = 0, rets = 0;
  logic tbt_en = 0, irq = 0, tfall = 0, srel = 0;
  logic [3:0] mode;
  logic fast_en, slow_en, cpu_run, per_en, tbt_clk, stop_act, tbt_set, frst, cerr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr),
    .wr_fosc_i(fosc), .wr_sosc_i(sosc), .wr_csel_i(csel),
    .wr_idle_i(idle), .wr_halt_i(halt), .wr_stop_i(stp), .wr_ret_slow_i(rets),
    .tbt_en_i(tbt_en), .irq_i(irq), .tbt_fall_i(tfall), .stop_rel_i(srel),
    .mode_o(mode), .fast_osc_en_o(fast_en), .slow_osc_en_o(slow_en),
    .cpu_run_o(cpu_run), .periph_clk_en_o(per_en), .tbt_clk_en_o(tbt_clk),
    .stop_active_o(stop_act), .tbt_irq_set_o(tbt_set),
    .force_rst_o(frst), .cfg_err_o(cerr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one write cycle; returns at the next falling edge with outputs settled
  task automatic do_wr(input logic f, s, c, i, h, st, r, te);
    @(negedge clk);
    wr = 1; fosc = f; sosc = s; csel = c; idle = i; halt = h; stp = st; rets = r; tbt_en = te;
    @(negedge clk);
    wr = 0; idle = 0; halt = 0; stp = 0; rets = 0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1; @(negedge clk); irq = 0;
  endtask

  task automatic pulse_fall();
    @(negedge clk); tfall = 1; @(negedge clk); tfall = 0;
  endtask

  task automatic pulse_rel();
    @(negedge clk); srel = 1; @(negedge clk); srel = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 fast_en", fast_en, 1);
    chk("R1 slow_en", slow_en, 0);
    chk("R1 cpu_run", cpu_run, 1);
    chk("R1 periph", per_en, 1);
  endtask

  task automatic t_run_modes();
    do_wr(1, 1, 0, 0, 0, 0, 0, 0); chk("R2 normal2", mode, 1);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0); chk("R2 slow2", mode, 2);
    do_wr(0, 1, 1, 0, 0, 0, 0, 0); chk("R2 slow1", mode, 3);
    chk("R2 slow1 fast off", fast_en, 0);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0); chk("R2 back slow2", mode, 2);
    do_wr(1, 1, 0, 0, 0, 0, 0, 0); chk("R2 back normal2", mode, 1);
  endtask

  task automatic t_light();
    pulse_irq(); chk("R3 irq ignored in run", mode, 1);
    do_wr(1, 1, 0, 1, 0, 0, 0, 0); chk("R3 idle2", mode, 5);
    chk("R11 idle cpu off", cpu_run, 0);
    chk("R11 idle periph on", per_en, 1);
    repeat (3) @(negedge clk);
    chk("R3 idle2 holds", mode, 5);
    do_wr(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 write in idle frst", frst, 0);
    chk("R9 write in idle mode", mode, 5);
    pulse_irq(); chk("R3 idle2 release", mode, 1);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0);
    do_wr(0, 1, 1, 1, 0, 0, 0, 0); chk("R3 sleep1", mode, 6);
    pulse_irq(); chk("R3 sleep1 release", mode, 3);
  endtask

  task automatic t_halt();
    do_wr(0, 1, 1, 0, 1, 0, 0, 1); chk("R4 sleep0", mode, 9);
    chk("R4 sleep0 periph off", per_en, 0);
    chk("R4 sleep0 tbt clk", tbt_clk, 1);
    pulse_irq(); chk("R4 irq ignored", mode, 9);
    pulse_fall();
    chk("R4 sleep0 release", mode, 3);
    chk("R5 tbt set", tbt_set, 1);
    @(negedge clk); chk("R5 tbt set one cycle", tbt_set, 0);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0);
    do_wr(1, 1, 0, 0, 0, 0, 0, 0);
    do_wr(1, 1, 0, 0, 1, 0, 0, 0); chk("R4 idle0", mode, 8);
    pulse_fall();
    chk("R4 idle0 release normal1", mode, 0);
    chk("R4 idle0 slow osc cleared", slow_en, 0);
    chk("R5 no tbt set", tbt_set, 0);
  endtask

  task automatic t_illegal();
    do_wr(1, 1, 0, 0, 0, 0, 0, 0);
    do_wr(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 fast off while selected", frst, 1);
    chk("R6 mode", mode, 0);
    @(negedge clk); chk("R6 pulse one cycle", frst, 0);
    do_wr(0, 0, 0, 0, 0, 0, 0, 0); chk("R6 both off", frst, 1);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0);
    do_wr(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 slow off while selected", frst, 1);
    chk("R6 slow case mode", mode, 0);
  endtask

  task automatic t_conflict();
    do_wr(1, 1, 0, 1, 1, 0, 0, 0);
    chk("R7 err pulse", cerr, 1);
    chk("R7 mode unchanged", mode, 0);
    chk("R7 slow osc unchanged", slow_en, 0);
    @(negedge clk); chk("R7 err one cycle", cerr, 0);
  endtask

  task automatic t_stop();
    do_wr(1, 1, 0, 0, 0, 0, 0, 0);
    do_wr(1, 1, 0, 0, 0, 1, 0, 0);
    chk("R8 stop mode", mode, 10);
    chk("R8 osc off", fast_en | slow_en, 0);
    chk("R8 stop active", stop_act, 1);
    chk("R11 stop periph off", per_en, 0);
    pulse_irq(); chk("R8 irq ignored", mode, 10);
    pulse_rel(); chk("R8 return normal2", mode, 1);
    do_wr(1, 1, 0, 0, 0, 1, 1, 0);
    pulse_rel(); chk("R8 return slow1", mode, 3);
    chk("R8 slow1 fast off", fast_en, 0);
    do_wr(1, 1, 1, 0, 0, 0, 0, 0);
    do_wr(1, 1, 0, 0, 0, 0, 0, 0);
    do_wr(1, 0, 0, 0, 0, 0, 0, 0); chk("R2 normal1", mode, 0);
    do_wr(1, 0, 0, 0, 0, 1, 1, 0);
    chk("R10 err pulse", cerr, 1);
    chk("R10 mode unchanged", mode, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_modes();
    t_light();
    t_halt();
    t_illegal();
    t_conflict();
    t_stop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule